// File: doc/BRIEF.md
# Write-After-Read Bus Grant Arbiter

This block drives the bus grant of a single processor master that shares its data bus with a slow peripheral. When a processor cycle selects the slow peripheral, the arbiter drops the grant. The processor still finishes that cycle. Afterwards it has to release its bus drivers for one clock. The slow device's data drivers can therefore turn off before the processor begins a following write. This removes the read-then-write contention on the shared data lines.

The arbiter does not choose between masters. Outside peripheral cycles it keeps the grant parked on the processor for as long as the request is held. A peripheral cycle is recognised when any of three decoded selects is high during a processor cycle: a register chip select, a data strobe select or a block-transfer select. A processor cycle runs from the transfer start pulse until the clock in which the transfer acknowledge is sampled. Once the acknowledge of a revoked cycle is seen, the grant returns for one regrant clock and the arbiter then goes back to parked operation.

Top module: `wbr_grant_arb`

## Requirements
- R1: While reset is held, `bus_grant` is 0. After reset it stays 0 until `bus_req` is sampled high, and it is 1 from the clock after that sample.
- R2: While `bus_req` is 1 and no peripheral cycle occurs, `bus_grant` stays 1 without a gap, including through cycles that raise none of the three selects.
- R3: If any one of `sel_chip`, `sel_strobe` or `sel_block` is 1 in a clock where a cycle is in progress (`xfer_start` is 1 in that clock, or an earlier start has not yet been acknowledged), `bus_grant` is 0 from the next clock.
- R4: Selects that are high while no cycle is in progress have no effect on `bus_grant`.
- R5: After a revoke, `bus_grant` stays 0 until `xfer_ack` is sampled 1. It is 1 again from the next clock if `bus_req` is still 1.
- R6: The regrant state lasts exactly one clock and is followed by parked operation. The grant is only withdrawn again by a new peripheral cycle.
- R7: Every peripheral cycle produces at least one clock with `bus_grant` at 0.
- R8: In the granted state, when `bus_req` is 0 the grant is removed at the clock after the current cycle's acknowledge, or at the next clock if no cycle is in progress.
- R9: If `bus_req` is 0 when a revoked cycle is acknowledged, `bus_grant` stays 0 until `bus_req` is sampled 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Processor bus request, active high |
| sel_chip | input | 1 | Decoded peripheral register select, active high |
| sel_strobe | input | 1 | Decoded peripheral data strobe select, active high |
| sel_block | input | 1 | Decoded block-transfer select, active high |
| xfer_start | input | 1 | Transfer start pulse from the processor |
| xfer_ack | input | 1 | Transfer acknowledge ending a cycle |
| bus_grant | output | 1 | Bus grant to the processor, active high |

## Verification
The assertions check the single-clock relations on every cycle:
- a grant with a pending request and no hit stays up;
- a hit drops the grant at the next clock;
- a revoked grant stays down until the acknowledge;
- regrant never lasts two clocks;
- a released request drops an idle grant.

The bench's scenarios are needed for longer behaviour:
- the first grant after reset;
- the dead clock on each of the three selects taken alone;
- selects that appear outside a cycle;
- a request withdrawn during a revoked cycle;
- the agreement of long random processor traffic with an independent model of the grant.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int unsigned SEL_CNT = 3;

  typedef enum logic [1:0] {
    ST_RELEASED = 2'd0,
    ST_PARKED   = 2'd1,
    ST_REVOKED  = 2'd2,
    ST_REGRANT  = 2'd3
  } arb_state_e;

  function automatic logic grant_of(arb_state_e s);
    return (s == ST_PARKED) || (s == ST_REGRANT);
  endfunction

  function automatic arb_state_e next_granted(logic hit, logic req,
                                              logic in_cyc, logic cyc_end);
    if (hit)                         return ST_REVOKED;
    if (!req && (!in_cyc || cyc_end)) return ST_RELEASED;
    return ST_PARKED;
  endfunction
endpackage

// File: rtl/wbr_cycle_track.sv
module wbr_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic xfer_ack,
  output logic busy,
  output logic in_cycle,
  output logic cycle_end
);
  assign in_cycle  = busy | xfer_start;
  assign cycle_end = in_cycle & xfer_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= in_cycle & ~xfer_ack;
  end
endmodule

// File: rtl/wbr_sel_detect.sv
module wbr_sel_detect #(
  parameter int unsigned N = wbr_pkg::SEL_CNT
) (
  input  logic [N-1:0] sel_vec,
  input  logic         in_cycle,
  output logic         periph_hit
);
  assign periph_hit = in_cycle & (|sel_vec);
endmodule

// File: rtl/wbr_grant_fsm.sv
module wbr_grant_fsm
  import wbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       periph_hit,
  input  logic       busy,
  input  logic       in_cycle,
  input  logic       cycle_end,
  input  logic       xfer_ack,
  output arb_state_e state,
  output logic       grant
);
  arb_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RELEASED: state_nx = bus_req ? ST_PARKED : ST_RELEASED;
      ST_PARKED,
      ST_REGRANT:  state_nx = next_granted(periph_hit, bus_req, in_cycle, cycle_end);
      ST_REVOKED:
        if (xfer_ack || !busy) state_nx = bus_req ? ST_REGRANT : ST_RELEASED;
      default:     state_nx = ST_RELEASED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RELEASED;
    else        state <= state_nx;
  end

  assign grant = grant_of(state);
endmodule

// File: rtl/wbr_grant_arb.sv
module wbr_grant_arb
  import wbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic sel_chip,
  input  logic sel_strobe,
  input  logic sel_block,
  input  logic xfer_start,
  input  logic xfer_ack,
  output logic bus_grant
);
  localparam int unsigned NSEL = SEL_CNT;

  logic [NSEL-1:0] sel_vec;
  logic            busy, in_cycle, cycle_end, periph_hit;
  arb_state_e      state;

  assign sel_vec = {sel_block, sel_strobe, sel_chip};

  wbr_cycle_track u_track (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
    .busy(busy), .in_cycle(in_cycle), .cycle_end(cycle_end)
  );

  wbr_sel_detect #(.N(NSEL)) u_sel (
    .sel_vec(sel_vec), .in_cycle(in_cycle), .periph_hit(periph_hit)
  );

  wbr_grant_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .periph_hit(periph_hit),
    .busy(busy), .in_cycle(in_cycle), .cycle_end(cycle_end),
    .xfer_ack(xfer_ack), .state(state), .grant(bus_grant)
  );
endmodule

// File: rtl/wbr_grant_arb_chk.sv
module wbr_grant_arb_chk
  import wbr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       xfer_ack,
  input logic       bus_grant,
  input logic       periph_hit,
  input logic       in_cycle,
  input logic       busy,
  input arb_state_e state
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant && !bus_req && state == ST_RELEASED) |=> !bus_grant); // R1
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req && !periph_hit) |=> bus_grant); // R2
  AST_SEL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && bus_req && !in_cycle) |=> bus_grant); // R4
  AST_HIT_REVOKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && periph_hit) |=> !bus_grant); // R3
  AST_WAIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REVOKED && busy && !xfer_ack) |=> !bus_grant); // R5
  AST_ACK_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REVOKED && xfer_ack && bus_req) |=> bus_grant); // R5
  AST_REGRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REGRANT) |=> (state != ST_REGRANT)); // R6
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !bus_req && !in_cycle) |=> !bus_grant); // R8
  AST_ACK_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REVOKED && xfer_ack && !bus_req) |=> !bus_grant); // R9
endmodule

bind wbr_grant_arb wbr_grant_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .xfer_ack(xfer_ack),
  .bus_grant(bus_grant), .periph_hit(periph_hit), .in_cycle(in_cycle),
  .busy(busy), .state(state)
);

// File: tb/test_wbr_grant_arb.sv
module test_wbr_grant_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, sel_chip = 0, sel_strobe = 0, sel_block = 0;
  logic xfer_start = 0, xfer_ack = 0;
  logic bus_grant;

  int checks = 0;
  int errors = 0;

  // model: 0 released, 1 granted, 2 revoked
  int   m_mode = 0;
  logic m_busy = 1'b0;

  always #2 clk = ~clk;

  wbr_grant_arb i_wbr_grant_arb (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .sel_chip(sel_chip),
    .sel_strobe(sel_strobe), .sel_block(sel_block), .xfer_start(xfer_start),
    .xfer_ack(xfer_ack), .bus_grant(bus_grant)
  );

  function automatic int model_next(int mode, logic bsy, logic req, logic st,
                                    logic [2:0] sel, logic ack);
    logic cyc;
    cyc = bsy | st;
    case (mode)
      1: if (cyc && sel != 3'b000) return 2;
         else if (!req && (!cyc || ack)) return 0;
         else return 1;
      2: if (ack || !bsy) return req ? 1 : 0;
         else return 2;
      default: return req ? 1 : 0;
    endcase
  endfunction

  function automatic logic model_grant(int mode);
    return mode == 1;
  endfunction

  task automatic check(logic exp, string tag);
    checks++;
    if (bus_grant !== exp) begin
      errors++;
      $display("FAIL %s grant actual=%0b expected=%0b at %0t", tag, bus_grant, exp, $time);
    end
  endtask

  // drive one clock of inputs at a negedge, then check at the next negedge
  task automatic step(logic req, logic st, logic [2:0] sel, logic ack, string tag);
    bus_req = req; xfer_start = st; xfer_ack = ack;
    {sel_block, sel_strobe, sel_chip} = sel;
    m_mode = model_next(m_mode, m_busy, req, st, sel, ack);
    m_busy = (m_busy | st) & ~ack;
    @(negedge clk);
    check(model_grant(m_mode), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 reset");
    rst_n = 1'b1;
    step(0, 0, 3'b000, 0, "R1 idle after reset");
    step(0, 0, 3'b000, 0, "R1 idle after reset");
    step(1, 0, 3'b000, 0, "R1 first grant");
    // plain cycle, no selects
    step(1, 1, 3'b000, 0, "R2 plain start");
    step(1, 0, 3'b000, 0, "R2 plain wait");
    step(1, 0, 3'b000, 1, "R2 plain ack");
    // select outside any cycle
    step(1, 0, 3'b111, 0, "R4 select no cycle");
    step(1, 0, 3'b010, 0, "R4 select no cycle");
    // each select alone gives a dead clock
    for (int b = 0; b < 3; b++) begin
      step(1, 1, 3'(1 << b), 0, "R3 hit");
      step(1, 0, 3'(1 << b), 0, "R5 wait ack");
      step(1, 0, 3'(1 << b), 1, "R7 ack dead clock");
      step(1, 0, 3'b000, 0, "R6 regrant to parked");
      step(1, 0, 3'b000, 0, "R6 parked holds");
    end
    // select raised mid-cycle
    step(1, 1, 3'b000, 0, "R2 start");
    step(1, 0, 3'b100, 0, "R3 late select");
    step(1, 0, 3'b100, 1, "R5 ack");
    step(1, 0, 3'b000, 0, "R6 back");
    // request dropped during revoke
    step(1, 1, 3'b001, 0, "R3 hit");
    step(0, 0, 3'b001, 0, "R5 still revoked");
    step(0, 0, 3'b001, 1, "R9 ack without req");
    step(0, 0, 3'b000, 0, "R9 stays released");
    step(1, 0, 3'b000, 0, "R9 regrant on req");
    // request dropped during plain cycle
    step(1, 1, 3'b000, 0, "R2 start");
    step(0, 0, 3'b000, 0, "R8 hold until ack");
    step(0, 0, 3'b000, 1, "R8 release at ack");
    step(1, 0, 3'b000, 0, "R1 regain");
    step(0, 0, 3'b000, 0, "R8 idle release");
    step(1, 0, 3'b000, 0, "R1 regain");
    // constrained random processor traffic
    void'($urandom(32'h5eed_0420));
    for (int n = 0; n < 3000; n++) begin
      logic req, st, ack;
      logic [2:0] sel;
      req = ($urandom % 8) != 0;
      st  = !m_busy && model_grant(m_mode) && (($urandom % 3) == 0);
      ack = m_busy && (($urandom % 3) == 0);
      sel = (($urandom % 2) == 0) ? 3'($urandom % 8) : 3'b000;
      step(req, st, sel, ack, "R2 R3 R5 R8 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule